// File: doc/BRIEF.md
# Prescaled Capture-Compare Base Timer

This block is the shared 16-bit time base for a bank of capture/compare channels. It counts events from one of two internal clock enables, or it decodes a two-phase (quadrature) input pair. Every source event first passes a divide-by-(n+1) prescaler, where n is an 8-bit setting. The running count is driven out to the channels on `count`.

There are three count modes: up only, up/down under a direction input, and two-phase decoding. Three reset sources can each be enabled on its own:
- a match with the channel-0 compare value,
- a low level on the external interrupt input,
- a match with a dedicated reset value.

A single interrupt pulse, `irq`, marks a wrap from 0xFFFF to 0 while counting up, or a clear caused by the reset-value match.

Top module: `cc_base_timer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `count` is 0 and `irq` is 0.
- R2: In up mode (`mode_sel`=0), the counter increments once per (n+1) events of the source picked by `src_sel` (0 = `tick_a`, 1 = `tick_b`). The other source and `dir_down` have no effect. The count changes on the clock edge that samples the completing event.
- R3: With `div_n`=0 every source event counts. With `div_n`=255, 256 events make one count.
- R4: In up/down mode (`mode_sel`=1), `dir_down`=1 decrements and `dir_down`=0 increments. A decrement from 0 gives 0xFFFF and raises no interrupt.
- R5: In two-phase mode (`mode_sel`=2), each single-bit step of {`phase_a`,`phase_b`} through 00,10,11,01,00 (A leading) counts up, and each step in the reverse order counts down. The phases pass a two-flop synchroniser, so the count changes on the third rising edge after a phase change.
- R6: With `cmp0_rst_en`=1, a cycle in which `count` equals `cmp0_val` makes `count` 0 on the next edge. A clear takes priority over any count event in that cycle.
- R7: With `ext_rst_en`=1, a low on `ext_int_n` clears `count` on the third rising edge after it is applied. With `ext_rst_en`=0 the pin has no effect.
- R8: With `rld_rst_en`=1, a cycle in which `count` equals `rld_val` makes `count` 0 and `irq` 1 on the next edge.
- R9: An up count from 0xFFFF gives 0 with `irq` high for exactly that one cycle.
- R10: With `run`=0, or with `mode_sel`=3, no event changes the count. The prescaler state is cleared while `run` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable |
| mode_sel | input | 2 | 0 up, 1 up/down, 2 two-phase, 3 hold |
| src_sel | input | 1 | Internal source select |
| tick_a | input | 1 | Internal clock enable A |
| tick_b | input | 1 | Internal clock enable B |
| dir_down | input | 1 | Direction in up/down mode |
| div_n | input | 8 | Prescaler setting n, divide by n+1 |
| phase_a | input | 1 | Two-phase input A (asynchronous) |
| phase_b | input | 1 | Two-phase input B (asynchronous) |
| cmp0_val | input | 16 | Channel-0 compare value |
| cmp0_rst_en | input | 1 | Enable clear on compare-0 match |
| ext_int_n | input | 1 | External interrupt pin, active low (asynchronous) |
| ext_rst_en | input | 1 | Enable clear on external low level |
| rld_val | input | 16 | Dedicated reset value |
| rld_rst_en | input | 1 | Enable clear on reset-value match |
| count | output | 16 | Base timer value |
| irq | output | 1 | Base timer interrupt pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit prescaler setting and two synchroniser stages.

At 16 bits, holding a source enable high reaches the full wrap in 65,536 cycles, so the overflow pulse is exercised directly rather than through a preload. The 8-bit setting lets the bench reach the largest divide ratio of 256 within a few hundred events.

The two-stage synchroniser fixes a three-edge latency for the phase pins and the external pin, and the bench samples those paths exactly there.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {
    CM_UP   = 2'd0,
    CM_UPDN = 2'd1,
    CM_QUAD = 2'd2,
    CM_HOLD = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cbt_sync.sv
module cbt_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/cbt_quad_dec.sv
module cbt_quad_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic a_s,
  input  logic b_s,
  output logic step,
  output logic step_up
);
  logic a_q, b_q;
  logic a_chg, b_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_s;
      b_q <= b_s;
    end
  end

  always_comb begin
    a_chg   = a_s ^ a_q;
    b_chg   = b_s ^ b_q;
    step    = a_chg ^ b_chg;   // exactly one phase moved
    step_up = a_s ^ b_q;       // A leading B gives up
  end
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ev,
  input  logic             ev_up,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick,
  output logic             tick_up
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d   = cnt_q;
    tick    = 1'b0;
    tick_up = ev_up;
    if (!run) begin
      cnt_d = '0;
    end else if (ev) begin
      if (cnt_q >= div_n) begin
        tick  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cbt_core.sv
module cbt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tick_up,
  input  logic             clr,
  input  logic             rld_hit,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;

  always_comb begin
    cnt_d = cnt_q;
    irq_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
      irq_d = rld_hit;
    end else if (tick) begin
      if (tick_up) begin
        cnt_d = cnt_q + 1'b1;
        irq_d = (cnt_q == CNT_MAX);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign count = cnt_q;
  assign irq   = irq_q;
endmodule

// File: rtl/cc_base_timer.sv
module cc_base_timer
  import cbt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       mode_sel,
  input  logic             src_sel,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             dir_down,
  input  logic [DIV_W-1:0] div_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic [CNT_W-1:0] cmp0_val,
  input  logic             cmp0_rst_en,
  input  logic             ext_int_n,
  input  logic             ext_rst_en,
  input  logic [CNT_W-1:0] rld_val,
  input  logic             rld_rst_en,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  cnt_mode_e  mode;
  logic [1:0] ph_s;
  logic       ext_s;
  logic       q_step, q_up;
  logic       src_ev, ev, ev_up;
  logic       pre_tick, pre_up;
  logic       cmp0_hit, rld_hit, ext_hit, clr;

  cbt_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_ph_sync (
    .clk(clk), .rst_n(rst_n), .d_in({phase_a, phase_b}), .d_out(ph_s)
  );

  cbt_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d_in(ext_int_n), .d_out(ext_s)
  );

  cbt_quad_dec u_qdec (
    .clk(clk), .rst_n(rst_n), .a_s(ph_s[1]), .b_s(ph_s[0]),
    .step(q_step), .step_up(q_up)
  );

  always_comb begin
    mode   = cnt_mode_e'(mode_sel);
    src_ev = src_sel ? tick_b : tick_a;
    ev     = 1'b0;
    ev_up  = 1'b1;
    case (mode)
      CM_UP:   begin ev = src_ev; ev_up = 1'b1;      end
      CM_UPDN: begin ev = src_ev; ev_up = !dir_down; end
      CM_QUAD: begin ev = q_step; ev_up = q_up;      end
      default: begin ev = 1'b0;   ev_up = 1'b1;      end
    endcase
  end

  cbt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .ev(ev), .ev_up(ev_up),
    .div_n(div_n), .tick(pre_tick), .tick_up(pre_up)
  );

  always_comb begin
    cmp0_hit = cmp0_rst_en && (count == cmp0_val);
    rld_hit  = rld_rst_en && (count == rld_val);
    ext_hit  = ext_rst_en && !ext_s;
    clr      = cmp0_hit || rld_hit || ext_hit;
  end

  cbt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick), .tick_up(pre_up),
    .clr(clr), .rld_hit(rld_hit), .count(count), .irq(irq)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [1:0]       mode_sel,
  input logic [CNT_W-1:0] cmp0_val,
  input logic             cmp0_rst_en,
  input logic             ext_rst_en,
  input logic [CNT_W-1:0] rld_val,
  input logic             rld_rst_en,
  input logic [CNT_W-1:0] count,
  input logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic no_clr;
  assign no_clr = !cmp0_rst_en && !ext_rst_en && !rld_rst_en;

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == '0)); // R9

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ((!run || mode_sel == 2'd3) && no_clr) |=> $stable(count)); // R10

  AST_CMP0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp0_rst_en && count == cmp0_val) |=> (count == '0)); // R6

  AST_RLD_CLEARS_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_rst_en && count == rld_val) |=> (irq && count == '0)); // R8

  AST_UP_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd0 && no_clr && count != CNT_MAX) |=> (count >= $past(count))); // R2
endmodule

bind cc_base_timer cbt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mode_sel(mode_sel),
  .cmp0_val(cmp0_val), .cmp0_rst_en(cmp0_rst_en), .ext_rst_en(ext_rst_en),
  .rld_val(rld_val), .rld_rst_en(rld_rst_en), .count(count), .irq(irq)
);

// File: tb/sim_cc_base_timer.sv
module sim_cc_base_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic [1:0]  mode_sel;
  logic        src_sel, tick_a, tick_b, dir_down;
  logic [7:0]  div_n;
  logic        phase_a, phase_b;
  logic [15:0] cmp0_val, rld_val;
  logic        cmp0_rst_en, ext_int_n, ext_rst_en, rld_rst_en;
  logic [15:0] count;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cc_base_timer u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .mode_sel(mode_sel),
    .src_sel(src_sel), .tick_a(tick_a), .tick_b(tick_b), .dir_down(dir_down),
    .div_n(div_n), .phase_a(phase_a), .phase_b(phase_b),
    .cmp0_val(cmp0_val), .cmp0_rst_en(cmp0_rst_en), .ext_int_n(ext_int_n),
    .ext_rst_en(ext_rst_en), .rld_val(rld_val), .rld_rst_en(rld_rst_en),
    .count(count), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        src;
    logic        dir;
    logic        wrong;
    logic [7:0]  div;
    logic [9:0]  nev;
    logic [15:0] exp;
  } vec_t;

  // R2, R3, R4 vectors: mode, src, dir, pulse other source, div, events, expected
  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 8'd0,   10'd5,   16'd5},
    '{2'd0, 1'b1, 1'b0, 1'b0, 8'd0,   10'd7,   16'd7},
    '{2'd0, 1'b0, 1'b0, 1'b0, 8'd2,   10'd9,   16'd3},
    '{2'd1, 1'b0, 1'b1, 1'b0, 8'd0,   10'd3,   16'hFFFD},
    '{2'd1, 1'b1, 1'b0, 1'b0, 8'd1,   10'd6,   16'd3},
    '{2'd0, 1'b0, 1'b1, 1'b0, 8'd0,   10'd4,   16'd4},
    '{2'd0, 1'b0, 1'b0, 1'b1, 8'd0,   10'd6,   16'd0},
    '{2'd0, 1'b1, 1'b0, 1'b0, 8'd255, 10'd256, 16'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b1; mode_sel = 2'd0; src_sel = 1'b0;
    tick_a = 1'b0; tick_b = 1'b0; dir_down = 1'b0; div_n = 8'd0;
    phase_a = 1'b0; phase_b = 1'b0; cmp0_val = 16'd0; rld_val = 16'd0;
    cmp0_rst_en = 1'b0; ext_int_n = 1'b1; ext_rst_en = 1'b0; rld_rst_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_src(input logic use_b);
    if (use_b) tick_b = 1'b1; else tick_a = 1'b1;
    @(negedge clk);
    tick_a = 1'b0; tick_b = 1'b0;
    @(negedge clk);
  endtask

  // holds the current source high for k edges, then samples
  task automatic hold_src(input int k);
    tick_a = 1'b1;
    repeat (k) @(posedge clk);
    @(negedge clk);
    tick_a = 1'b0;
  endtask

  task automatic set_phase(input logic a, input logic b);
    phase_a = a; phase_b = b;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 count", count, 16'd0);
    chk("R1 irq", irq, 1'b0);

    // R2 R3 R4: vector table
    for (int v = 0; v < 8; v++) begin
      do_reset();
      mode_sel = VECS[v].mode; src_sel = VECS[v].src;
      dir_down = VECS[v].dir; div_n = VECS[v].div;
      @(negedge clk);
      for (int e = 0; e < int'(VECS[v].nev); e++)
        pulse_src(VECS[v].src ^ VECS[v].wrong);
      chk($sformatf("R2/R3/R4 vec%0d count", v), count, VECS[v].exp);
      chk($sformatf("R4 vec%0d no irq", v), irq, 1'b0);
    end

    // R9: overflow wrap with one-cycle irq
    do_reset();
    hold_src(65535);
    chk("R9 count at max", count, 16'hFFFF);
    chk("R9 irq before wrap", irq, 1'b0);
    tick_a = 1'b1;
    @(negedge clk);
    tick_a = 1'b0;
    chk("R9 count wrapped", count, 16'd0);
    chk("R9 irq on wrap", irq, 1'b1);
    @(negedge clk);
    chk("R9 irq one cycle", irq, 1'b0);

    // R5: two-phase decoding with sync latency
    do_reset();
    mode_sel = 2'd2;
    @(negedge clk);
    phase_a = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 latency before third edge", count, 16'd0);
    @(negedge clk);
    chk("R5 count on third edge", count, 16'd1);
    @(negedge clk);
    set_phase(1'b1, 1'b1);
    set_phase(1'b0, 1'b1);
    set_phase(1'b0, 1'b0);
    chk("R5 forward four steps", count, 16'd4);
    set_phase(1'b0, 1'b1);
    set_phase(1'b1, 1'b1);
    chk("R5 reverse two steps", count, 16'd2);

    // R6: compare-0 match clear
    do_reset();
    cmp0_val = 16'd5; cmp0_rst_en = 1'b1;
    hold_src(5);
    chk("R6 count at match", count, 16'd5);
    tick_a = 1'b1;
    @(negedge clk);
    tick_a = 1'b0;
    chk("R6 cleared over count", count, 16'd0);
    chk("R6 no irq", irq, 1'b0);

    // R8: reset-value match clear with irq
    do_reset();
    rld_val = 16'd3; rld_rst_en = 1'b1;
    hold_src(3);
    chk("R8 count at match", count, 16'd3);
    @(negedge clk);
    chk("R8 cleared", count, 16'd0);
    chk("R8 irq", irq, 1'b1);

    // R7 and R10: external clear, run low
    do_reset();
    hold_src(6);
    run = 1'b0;
    for (int e = 0; e < 4; e++) pulse_src(1'b0);
    chk("R10 run low holds", count, 16'd6);
    ext_rst_en = 1'b1; ext_int_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 before third edge", count, 16'd6);
    @(negedge clk);
    chk("R7 cleared", count, 16'd0);

    do_reset();
    hold_src(4);
    ext_int_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 disabled pin ignored", count, 16'd4);

    do_reset();
    mode_sel = 2'd3;
    for (int e = 0; e < 3; e++) pulse_src(1'b0);
    chk("R10 hold mode", count, 16'd0);

    summary();
  end
endmodule